// File: doc/BRIEF.md
# Sample Fetch Address Generator

This block produces the 16-bit memory address used to fetch sample bytes one after another. The host writes an 8-bit start value into a register. A restart strobe expands that value into a full start address. After each completed fetch, the fetch logic pulses an advance strobe, and the address moves up by one byte.

Only 15 bits of address state are stored. The top address bit is always driven high, so every fetch lands in the upper half of the address space. When the counter passes the end of memory, it wraps to 0x8000 and not to zero.

On restart, bit 14 is forced high and the low six bits are cleared. The host value fills bits 13 to 6. A write to the start register does not disturb a fetch run in progress. The new value takes effect at the next restart.

Top module: `sample_fetch_addr`

## Requirements
- R1: Output bit 15 (`addr_o[15]`) is 1 in every cycle.
- R2: While `rst_ni` is low, and after it is released with no strobe applied, `addr_o` is 0xC000 and the stored start value is 0x00.
- R3: A restart (`restart_i` high at a clock edge) makes `addr_o` read `{1'b1, 1'b1, start[7:0], 6'b000000}` from the next cycle onward. Here `start` is the value stored in the start register.
- R4: An advance (`advance_i` high at an edge, `restart_i` low) makes `addr_o` read its previous value plus one in the next cycle.
- R5: An advance from 0xFFFF gives 0x8000.
- R6: When `restart_i` and `advance_i` are high at the same edge, the restart wins and no increment is applied.
- R7: A start-register write (`wr_en_i` high, data on `wr_data_i`) leaves `addr_o` unchanged. The written value is used only at the next restart.
- R8: When a write and a restart happen at the same edge, the restart uses the value stored before that edge. The new value is used from the following restart on.
- R9: With no restart and no advance, `addr_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe for the start register |
| wr_data_i | input | 8 | Host start value |
| restart_i | input | 1 | Reload the address from the start register |
| advance_i | input | 1 | Advance the address by one byte after a fetch |
| addr_o | output | 16 | Current fetch address |

## Verification
The bench sweeps all 256 start values.
- For each value it checks the expanded address, which catches a design that drops bit 14, leaves the low bits dirty, or shifts the host field.
- Each run is then advanced to the end of its 64-byte window, to catch a carry into bit 14 or 15 that goes wrong.
- A start of 0xFF is pushed past 0xFFFF. A counter that wraps to zero would show 0x0000 instead of 0x8000.
- Simultaneous strobes and mid-run writes are applied. An address that moves on a write, or that increments despite a restart, would then show up directly at `addr_o`.

// File: rtl/sfa_pkg.sv
package sfa_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/sfa_start_reg.sv
module sfa_start_reg #(
  parameter int unsigned START_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [START_W-1:0] wr_data_i,
  output logic [START_W-1:0] start_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      start_o <= '0;
    else if (wr_en_i) start_o <= wr_data_i;
  end
endmodule

// File: rtl/sfa_op_sel.sv
module sfa_op_sel
  import sfa_pkg::*;
(
  input  logic    restart_i,
  input  logic    advance_i,
  output cnt_op_e op_o
);
  // restart has priority over advance
  always_comb begin
    if (restart_i)      op_o = OP_LOAD;
    else if (advance_i) op_o = OP_INC;
    else                op_o = OP_HOLD;
  end
endmodule

// File: rtl/sfa_addr_cnt.sv
module sfa_addr_cnt
  import sfa_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned START_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cnt_op_e            op_i,
  input  logic [START_W-1:0] start_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned CNT_W = ADDR_W - 1;
  localparam int unsigned LOW_W = CNT_W - 1 - START_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, load_val;

  assign load_val = {1'b1, start_i, {LOW_W{1'b0}}};

  always_comb begin
    unique case (op_i)
      OP_LOAD: cnt_d = load_val;
      OP_INC:  cnt_d = cnt_q + 1'b1; // wraps within CNT_W bits
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= {1'b1, {(CNT_W-1){1'b0}}};
    else         cnt_q <= cnt_d;
  end

  assign addr_o = {1'b1, cnt_q};
endmodule

// File: rtl/sample_fetch_addr.sv
module sample_fetch_addr
  import sfa_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned START_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [START_W-1:0] wr_data_i,
  input  logic               restart_i,
  input  logic               advance_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned LOW_W = ADDR_W - 2 - START_W;

  logic [START_W-1:0] start_q;
  cnt_op_e            op;

  sfa_start_reg #(.START_W(START_W)) u_start (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .start_o(start_q)
  );

  sfa_op_sel u_sel (.restart_i, .advance_i, .op_o(op));

  sfa_addr_cnt #(.ADDR_W(ADDR_W), .START_W(START_W)) u_cnt (
    .clk_i, .rst_ni, .op_i(op), .start_i(start_q), .addr_o
  );

  AST_TOP_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[ADDR_W-1]); // R1

  AST_RESTART_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (addr_o[ADDR_W-2] && addr_o[LOW_W-1:0] == '0
                   && addr_o[ADDR_W-3:LOW_W] == $past(start_q))); // R3

  AST_ADVANCE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !restart_i) |=>
      addr_o[ADDR_W-2:0] == $past(addr_o[ADDR_W-2:0]) + 1'b1); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!advance_i && !restart_i) |=> $stable(addr_o)); // R9
endmodule

// File: tb/sim_sample_fetch_addr.sv
module sim_sample_fetch_addr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [7:0]  wr_data = 0;
  logic        restart = 0;
  logic        advance = 0;
  logic [15:0] addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sample_fetch_addr u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .restart_i(restart), .advance_i(advance), .addr_o(addr)
  );

  task automatic chk(input logic [15:0] exp, input string req);
    checks++;
    if (addr !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h expected=%h", req, addr, exp);
    end
  endtask

  // drive at negedge, apply one edge, sample 1ns after it
  task automatic step(input logic w, input logic [7:0] d, input logic r, input logic a);
    @(negedge clk);
    wr_en = w; wr_data = d; restart = r; advance = a;
    @(posedge clk); #1;
    wr_en = 0; restart = 0; advance = 0;
  endtask

  function automatic logic [15:0] exp_start(input logic [7:0] s);
    return 16'hC000 | (16'(s) << 6);
  endfunction

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: addr=%h expected=done", addr);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12; chk(16'hC000, "R2 in reset");
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0); chk(16'hC000, "R2 after reset");
    step(0, 0, 1, 0); chk(16'hC000, "R2 start reg zero");
    // sweep all start values
    for (int s = 0; s < 256; s++) begin
      logic [15:0] e;
      step(1, 8'(s), 0, 0);
      step(0, 0, 1, 0);
      e = exp_start(8'(s));
      chk(e, "R3 restart form");
      if (addr[15] !== 1'b1) begin errors++; $display("FAIL R1: bit15=%b expected=1", addr[15]); end
      checks++;
      for (int k = 0; k < 63; k++) begin
        step(0, 0, 0, 1); e = e + 1'b1;
      end
      chk(e, "R4 advance to end of window");
      step(0, 0, 0, 0); chk(e, "R9 hold");
    end
    // wrap
    step(1, 8'hFF, 0, 0); step(0, 0, 1, 0);
    for (int k = 0; k < 63; k++) step(0, 0, 0, 1);
    chk(16'hFFFF, "R5 at top");
    step(0, 0, 0, 1); chk(16'h8000, "R5 wrap");
    step(0, 0, 0, 1); chk(16'h8001, "R4 after wrap");
    // priority
    step(1, 8'h12, 0, 0); step(0, 0, 1, 0); step(0, 0, 0, 1);
    chk(exp_start(8'h12) + 1, "R4 single step");
    step(0, 0, 1, 1); chk(exp_start(8'h12), "R6 restart beats advance");
    // mid-run write
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    step(1, 8'h77, 0, 0); chk(exp_start(8'h12) + 2, "R7 write no disturb");
    step(1, 8'h55, 0, 1); chk(exp_start(8'h12) + 3, "R7 write with advance");
    step(0, 0, 1, 0); chk(exp_start(8'h55), "R7 used at restart");
    // write with restart same edge
    step(1, 8'hA3, 1, 0); chk(exp_start(8'h55), "R8 old value used");
    step(0, 0, 1, 0); chk(exp_start(8'hA3), "R8 new value next");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule